// File: doc/BRIEF.md
# Two-wire serial memory slave controller

This block is the slave side of a two-wire serial bus that fronts an external 1024 x 8 byte store. It oversamples the clock line and the data line with the system clock, detects start and stop conditions, and decodes the first byte after a start as a device-address byte. When that byte matches, the block acknowledges it. It then takes a word address and accepts data bytes for a write, or streams bytes out for a read. The data line is never driven high: the block only asserts an open-drain pull-low enable.

The storage itself sits outside the block. It is reached through a plain port: an address, read data that is valid combinationally for that address, and a one-cycle write strobe with write data. The write strobe fires when a stop follows received data. The memory side then raises a busy input for the length of its internal write cycle. While busy is high the controller ignores the bus completely.

Top module: `twi_mem_slave`

## Requirements
- R1: The pull-low output changes only while the synchronised clock line is low. The exception is a clear forced by the busy input.
- R2: Bus traffic before the first start condition is ignored. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A full byte clocked before any start gets no acknowledge.
- R3: The device-address byte is received MSB first. Bits 7:4 must equal 4'b1010 and bit 3 must equal `strap_i`. Bits 2:1 are word-address bits 9:8, and bit 0 is 1 for a read and 0 for a write. On a match, SDA is pulled low through the ninth clock.
- R4: On a device-address mismatch, either in the type field or in the strap bit, there is no acknowledge. SDA stays released for all following bytes until the next start.
- R5: In a write, the next byte is the low eight bits of the word address, placed below bits 9:8 from the device byte. That byte and every data byte after it are acknowledged on their ninth clock.
- R6: A stop that follows at least one acknowledged data byte produces exactly one single-cycle `mem_we_o` pulse. The pulse carries the word address and the last data byte received. A stop with no data byte produces no write.
- R7: In a read, bytes from `mem_rdata_i` at the current word address go out MSB first. The address advances after each byte and wraps from 1023 to 0. An acknowledge from the master, with no stop, starts the next byte.
- R8: If the master does not acknowledge a read byte, the block releases SDA and does not drive it for any further clocks until the next start or stop.
- R9: While `busy_i` is high the block neither acknowledges nor drives SDA. This holds from the cycle after busy is seen.
- R10: A start received in the middle of a byte abandons the current transfer and restarts device-address reception.
- R11: After reset, SDA is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 1 | Pin-strapped device select bit |
| busy_i | input | 1 | Internal write cycle in progress |
| mem_rdata_i | input | 8 | Read data for `mem_addr_o` |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| mem_addr_o | output | 10 | Current word address |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |

## Verification
The embedded properties are checked on every cycle. They cover four rules: the pull-low output only changes in the low half of the clock, it is quiet in the idle state and while busy, write strobes appear only after a stop, and the word counter wraps from its top value to zero. Only the bench scenarios can show that whole transactions produce the right bytes. Those scenarios cover device-address decode against the strap, write commit of the last data byte, sequential reads across the wrap, silence after a missing acknowledge, and recovery through a repeated start in mid-byte.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DACK,
      ST_WADDR,
      ST_AACK,
      ST_WDATA,
      ST_WACK,
      ST_TX,
      ST_MACK
   } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int NLINES = 2;

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] lvl;
   logic [NLINES-1:0] lvl_q;

   assign raw = {scl_i, sda_i};

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_line_sync needs at least two stages");
      end
      for (genvar g = 0; g < NLINES; g++) begin : g_line
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
         end
         assign lvl[g] = pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '1;
      else        lvl_q <= lvl;
   end

   assign scl_s     = lvl[1];
   assign sda_s     = lvl[0];
   assign scl_rise  = lvl[1] & ~lvl_q[1];
   assign scl_fall  = ~lvl[1] & lvl_q[1];
   assign start_det = lvl[1] & lvl_q[1] & lvl_q[0] & ~lvl[0];
   assign stop_det  = lvl[1] & lvl_q[1] & ~lvl_q[0] & lvl[0];
endmodule

// File: rtl/twi_word_ctr.sv
module twi_word_ctr #(
   parameter int ADDR_W = 10,
   parameter int HI_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi_i,
   input  logic [HI_W-1:0]   hi_val_i,
   input  logic              ld_lo_i,
   input  logic [ADDR_W-HI_W-1:0] lo_val_i,
   input  logic              inc_i,
   output logic [ADDR_W-1:0] cnt_o
);
   localparam int LO_W = ADDR_W - HI_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (inc_i) begin
         cnt_o <= cnt_o + 1'b1;
      end else begin
         if (ld_hi_i) cnt_o[ADDR_W-1:LO_W] <= hi_val_i;
         if (ld_lo_i) cnt_o[LO_W-1:0]      <= lo_val_i;
      end
   end

   AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inc_i) && ($past(cnt_o) == {ADDR_W{1'b1}})) |-> (cnt_o == '0)); // R7
endmodule

// File: rtl/twi_frame_ctrl.sv
module twi_frame_ctrl
   import twi_pkg::*;
#(
   parameter int         HI_W     = 2,
   parameter logic [3:0] DEV_TYPE = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              strap_i,
   input  logic              busy_i,
   input  logic [BYTE_W-1:0] rd_byte_i,
   output logic              sda_pull_o,
   output logic              ld_hi_o,
   output logic [HI_W-1:0]   hi_val_o,
   output logic              ld_lo_o,
   output logic [BYTE_W-1:0] lo_val_o,
   output logic              inc_o,
   output logic              we_o,
   output logic [BYTE_W-1:0] wdata_o
);
   localparam logic [3:0] BITS_FULL = 4'd8;
   localparam logic [2:0] TX_LAST   = 3'd7;

   twi_state_e        state;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txsh;
   logic [2:0]        txcnt;
   logic              rw_q;
   logic              mack_q;
   logic              have_data;
   logic              byte_end;
   logic              dev_ok;

   assign byte_end = scl_fall && (bitcnt == BITS_FULL);
   assign dev_ok   = (shreg[7:4] == DEV_TYPE) && (shreg[3] == strap_i);
   assign hi_val_o = shreg[HI_W:1];
   assign lo_val_o = shreg;
   assign ld_hi_o  = !busy_i && !start_det && !stop_det && (state == ST_DEV) && byte_end && dev_ok;
   assign ld_lo_o  = !busy_i && !start_det && !stop_det && (state == ST_WADDR) && byte_end;
   assign inc_o    = !busy_i && (state == ST_TX) && scl_fall && (txcnt == TX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bitcnt     <= '0;
         shreg      <= '0;
         txsh       <= '0;
         txcnt      <= '0;
         rw_q       <= 1'b0;
         mack_q     <= 1'b0;
         have_data  <= 1'b0;
         sda_pull_o <= 1'b0;
         we_o       <= 1'b0;
         wdata_o    <= '0;
      end else begin
         we_o <= 1'b0;
         if (busy_i) begin
            state      <= ST_IDLE;
            sda_pull_o <= 1'b0;
            have_data  <= 1'b0;
         end else if (start_det) begin
            state      <= ST_DEV;
            bitcnt     <= '0;
            sda_pull_o <= 1'b0;
            have_data  <= 1'b0;
         end else if (stop_det) begin
            state      <= ST_IDLE;
            sda_pull_o <= 1'b0;
            we_o       <= have_data;
            have_data  <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_WADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end
                  if (byte_end) begin
                     bitcnt <= '0;
                     if (state == ST_DEV) begin
                        if (dev_ok) begin
                           state      <= ST_DACK;
                           rw_q       <= shreg[0];
                           sda_pull_o <= 1'b1;
                        end else begin
                           state      <= ST_IDLE;
                           sda_pull_o <= 1'b0;
                        end
                     end else if (state == ST_WADDR) begin
                        state      <= ST_AACK;
                        sda_pull_o <= 1'b1;
                     end else begin
                        state      <= ST_WACK;
                        wdata_o    <= shreg;
                        have_data  <= 1'b1;
                        sda_pull_o <= 1'b1;
                     end
                  end
               end
               ST_DACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        state      <= ST_TX;
                        txsh       <= rd_byte_i;
                        txcnt      <= '0;
                        sda_pull_o <= ~rd_byte_i[BYTE_W-1];
                     end else begin
                        state      <= ST_WADDR;
                        sda_pull_o <= 1'b0;
                     end
                  end
               end
               ST_AACK, ST_WACK: begin
                  if (scl_fall) begin
                     state      <= ST_WDATA;
                     sda_pull_o <= 1'b0;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (txcnt == TX_LAST) begin
                        state      <= ST_MACK;
                        sda_pull_o <= 1'b0;
                     end else begin
                        txcnt      <= txcnt + 3'd1;
                        txsh       <= {txsh[BYTE_W-2:0], 1'b0};
                        sda_pull_o <= ~txsh[BYTE_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack_q <= ~sda_s;
                  if (scl_fall) begin
                     if (mack_q) begin
                        state      <= ST_TX;
                        txsh       <= rd_byte_i;
                        txcnt      <= '0;
                        sda_pull_o <= ~rd_byte_i[BYTE_W-1];
                     end else begin
                        state      <= ST_IDLE;
                        sda_pull_o <= 1'b0;
                     end
                  end
               end
               default: begin
                  state      <= ST_IDLE;
                  sda_pull_o <= 1'b0;
               end
            endcase
         end
      end
   end

   AST_PULL_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_pull_o) && !$past(busy_i)) |-> !$past(scl_s)); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pull_o); // R4
   AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_i) |-> !sda_pull_o); // R9
   AST_WE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> $past(stop_det)); // R6
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
   parameter int         ADDR_W      = 10,
   parameter int         HI_W        = 2,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              strap_i,
   input  logic              busy_i,
   input  logic [7:0]        mem_rdata_i,
   output logic              sda_pull_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_we_o,
   output logic [7:0]        mem_wdata_o
);
   localparam int LO_W = ADDR_W - HI_W;

   generate
      if (LO_W != twi_pkg::BYTE_W) begin : g_bad_split
         $error("word address low part must be one byte");
      end
      if (HI_W != 2) begin : g_bad_hi
         $error("device byte carries exactly two high address bits");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic ld_hi, ld_lo, inc;
   logic [HI_W-1:0] hi_val;
   logic [LO_W-1:0] lo_val;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   twi_word_ctr #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ld_hi_i(ld_hi), .hi_val_i(hi_val),
      .ld_lo_i(ld_lo), .lo_val_i(lo_val), .inc_i(inc), .cnt_o(mem_addr_o)
   );

   twi_frame_ctrl #(.HI_W(HI_W), .DEV_TYPE(DEV_TYPE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .strap_i(strap_i), .busy_i(busy_i),
      .rd_byte_i(mem_rdata_i), .sda_pull_o(sda_pull_o), .ld_hi_o(ld_hi),
      .hi_val_o(hi_val), .ld_lo_o(ld_lo), .lo_val_o(lo_val), .inc_o(inc),
      .we_o(mem_we_o), .wdata_o(mem_wdata_o)
   );
endmodule

// File: tb/twi_mem_slave_tb.sv
module twi_mem_slave_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BUSY_CYC   = 600;
   localparam int WD_LIMIT   = 150000;

   typedef struct { logic [7:0] v; string tag; } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic strap = 1'b1;
   logic sda_pull, mem_we;
   logic [9:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;
   logic busy;
   logic sda_line;
   int busy_cnt = 0;
   int wr_cnt = 0;
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   logic [7:0] mem [1024];
   logic [7:0] ref_mem [1024];
   item_t exp_q[$];
   logic [7:0] obs_q[$];
   item_t m_e;
   logic [7:0] m_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line  = sda_m & ~sda_pull;
   assign mem_rdata = mem[mem_addr];
   assign busy      = (busy_cnt != 0);

   twi_mem_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .strap_i(strap), .busy_i(busy), .mem_rdata_i(mem_rdata),
      .sda_pull_o(sda_pull), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
      .mem_wdata_o(mem_wdata)
   );

   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         busy_cnt <= BUSY_CYC;
         wr_cnt <= wr_cnt + 1;
      end else if (busy_cnt != 0) begin
         busy_cnt <= busy_cnt - 1;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares each received byte against the expected queue
   always @(negedge clk) begin
      if (obs_q.size() > 0 && exp_q.size() > 0) begin
         m_e = exp_q.pop_front();
         m_o = obs_q.pop_front();
         check(m_e.tag, {24'd0, m_o}, {24'd0, m_e.v});
      end
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) ^ (a >> 3));
   endfunction

   function automatic logic [7:0] devb(input logic [1:0] hi, input logic s, input logic rd);
      return {4'b1010, s, hi, rd};
   endfunction

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic r);
      sda_m = b; w(4); scl = 1'b1; w(4); r = sda_line; w(4); scl = 1'b0; w(4);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; w(4); scl = 1'b1; w(6); sda_m = 1'b0; w(6); scl = 1'b0; w(4);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; w(4); scl = 1'b1; w(6); sda_m = 1'b1; w(6);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic r;
      for (int i = 7; i >= 0; i--) bit_x(b[i], r);
      bit_x(1'b1, r);
      acked = ~r;
   endtask

   task automatic recv_byte(input logic ack);
      logic r;
      logic [7:0] b = '0;
      for (int i = 0; i < 8; i++) begin
         bit_x(1'b1, r);
         b = {b[6:0], r};
      end
      bit_x(~ack, r);
      obs_q.push_back(b);
   endtask

   task automatic rd_expect(input int a, input logic ack, input string tag);
      item_t it;
      it.v = ref_mem[a];
      it.tag = tag;
      exp_q.push_back(it);
      recv_byte(ack);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      w(4);
   endtask

   initial begin
      logic ak;
      logic r;
      logic any_low;
      int wc;
      for (int a = 0; a < 1024; a++) begin
         mem[a] = pat(a);
         ref_mem[a] = pat(a);
      end
      w(5);
      check("R11 pull after reset", {31'd0, sda_pull}, 0);
      rst_n = 1'b1;
      w(5);
      check("R11 pull idle", {31'd0, sda_pull}, 0);
      check("R11 no write", wr_cnt, 0);

      // R2: full byte with no preceding start
      send_byte(devb(2'd0, 1'b1, 1'b0), ak);
      check("R2 no ack before start", {31'd0, ak}, 0);

      // R3 R5 R6: byte write to 0x2A5
      bus_start();
      send_byte(devb(2'd2, 1'b1, 1'b0), ak); check("R3 device ack", {31'd0, ak}, 1);
      send_byte(8'hA5, ak); check("R5 word addr ack", {31'd0, ak}, 1);
      send_byte(8'h5C, ak); check("R5 data ack", {31'd0, ak}, 1);
      bus_stop();
      w(4);
      ref_mem[10'h2A5] = 8'h5C;
      check("R6 one write", wr_cnt, 1);
      check("R6 written byte", {24'd0, mem[10'h2A5]}, 32'h5C);

      // R9: request during busy is ignored
      bus_start();
      send_byte(devb(2'd2, 1'b1, 1'b1), ak);
      check("R9 no ack while busy", {31'd0, ak}, 0);
      bus_stop();
      wait_idle();

      // R7 R8: random read then no acknowledge
      bus_start();
      send_byte(devb(2'd2, 1'b1, 1'b0), ak);
      send_byte(8'hA5, ak);
      bus_start();
      send_byte(devb(2'd2, 1'b1, 1'b1), ak); check("R3 read device ack", {31'd0, ak}, 1);
      rd_expect(10'h2A5, 1'b1, "R7 read first");
      rd_expect(10'h2A6, 1'b0, "R7 read sequential");
      any_low = 1'b0;
      for (int i = 0; i < 9; i++) begin
         bit_x(1'b1, r);
         if (!r) any_low = 1'b1;
      end
      check("R8 silent after nack", {31'd0, any_low}, 0);
      bus_stop();

      // R7: wrap from 1023 to 0
      bus_start();
      send_byte(devb(2'd3, 1'b1, 1'b0), ak);
      send_byte(8'hFF, ak);
      bus_start();
      send_byte(devb(2'd3, 1'b1, 1'b1), ak);
      rd_expect(1023, 1'b1, "R7 top address");
      rd_expect(0, 1'b1, "R7 wrapped address");
      rd_expect(1, 1'b0, "R7 after wrap");
      bus_stop();

      // R4: wrong type field, then wrong strap bit
      bus_start();
      send_byte(8'hB0, ak); check("R4 type mismatch no ack", {31'd0, ak}, 0);
      send_byte(8'h00, ak); check("R4 silent next byte", {31'd0, ak}, 0);
      bus_stop();
      bus_start();
      send_byte(devb(2'd0, 1'b0, 1'b0), ak); check("R4 strap mismatch no ack", {31'd0, ak}, 0);
      bus_stop();
      strap = 1'b0;
      bus_start();
      send_byte(devb(2'd0, 1'b0, 1'b0), ak); check("R3 strap low matches", {31'd0, ak}, 1);
      bus_stop();
      strap = 1'b1;

      // R10: repeated start four bits into a byte
      bus_start();
      send_byte(devb(2'd1, 1'b1, 1'b0), ak);
      for (int i = 0; i < 4; i++) bit_x(1'b0, r);
      bus_start();
      send_byte(devb(2'd1, 1'b1, 1'b0), ak); check("R10 device ack after restart", {31'd0, ak}, 1);
      send_byte(8'h10, ak); check("R10 addr ack after restart", {31'd0, ak}, 1);
      bus_start();
      send_byte(devb(2'd1, 1'b1, 1'b1), ak);
      rd_expect(10'h110, 1'b0, "R10 read after restart");
      bus_stop();

      // R6: stop with no data byte writes nothing
      wc = wr_cnt;
      bus_start();
      send_byte(devb(2'd0, 1'b1, 1'b0), ak);
      send_byte(8'h33, ak);
      bus_stop();
      w(10);
      check("R6 no write without data", wr_cnt, wc);

      // R6: two data bytes, last one is written at the word address
      bus_start();
      send_byte(devb(2'd0, 1'b1, 1'b0), ak);
      send_byte(8'h33, ak);
      send_byte(8'h11, ak);
      send_byte(8'h99, ak); check("R5 second data ack", {31'd0, ak}, 1);
      bus_stop();
      w(4);
      ref_mem[10'h033] = 8'h99;
      check("R6 single strobe", wr_cnt, wc + 1);
      check("R6 last byte kept", {24'd0, mem[10'h033]}, 32'h99);
      check("R6 neighbour untouched", {24'd0, mem[10'h034]}, {24'd0, pat(10'h034)});
      wait_idle();

      bus_start();
      send_byte(devb(2'd0, 1'b1, 1'b0), ak);
      send_byte(8'h33, ak);
      bus_start();
      send_byte(devb(2'd0, 1'b1, 1'b1), ak);
      rd_expect(10'h033, 1'b1, "R6 readback");
      rd_expect(10'h034, 1'b0, "R7 readback next");
      bus_stop();
      w(10);
      check("R7 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R11 watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule